// File: doc/BRIEF.md
# Single-cycle 32-bit scalar core

This block is a small, non-pipelined 32-bit processor. It completes one instruction per clock. Each instruction is fetched, decoded, executed and written back within that clock. It holds a 32-entry register file, a byte-addressed program counter, and two condition flags: zero (Z) and negative (N). There are no delay slots, no register windows, no traps and no carry or overflow flags.

Instruction fetch and data access use two combinational, word-indexed memory ports. A store that targets the last word of the memory also appears on a registered output with a single-cycle valid strobe. This gives a program a simple way to report results.

Any encoding outside the supported set stops the core for good until the next reset. So does any misaligned address, and any address beyond the memory. The instruction that causes the stop has no effect.

Top module: `scalar_core`

## Requirements
- R1: While reset is active and just after it, the PC is 0, `halted` and `out_valid` are low, Z and N are clear, and every register is 0 with two exceptions: r14 holds MEM_BYTES-124 and r8 holds MEM_BYTES-4.
- R2: Every cycle, `imem_addr` presents PC[WA+1:2]. An instruction that does not redirect the PC moves it to PC+4.
- R3: The major opcode sits in bits 31:30, rd in 29:25, rs1 in 18:14, the immediate-select bit in 13, simm13 in 12:0 and rs2 in 4:0. The arithmetic encodings are:
  - sethi (op=0, bits 24:22 = 4) writes bits 21:0 shifted left by 10 into rd.
  - add (op=2, op3 in 24:19 = 0x00) writes rs1 plus rs2 when bit 13 is 0, or rs1 plus sign-extended simm13 when bit 13 is 1.
  - sub (op3 = 0x04, bit 13 = 1) writes rs1 minus simm13.
- R4: Register 0 always reads as zero, and any write to it is dropped.
- R5: subcc (op=2, op3 = 0x14, bit 13 = 1) writes rs1 minus simm13. It sets N from bit 31 of the result and sets Z when the result is zero. No other instruction changes Z or N.
- R6: A branch is op=0 with bits 24:22 = 2. The condition in bits 28:25 selects the behaviour: 8 always branches, 1 branches when Z is set, and 9 branches when Z is clear. A taken branch moves the PC by 4 times the sign-extended bits 21:0.
- R7: call (op=1) writes the current PC into r15 and adds 4 times bits 29:0 to the PC. jmpl (op=2, op3 = 0x38, bit 13 = 1) writes the current PC into rd and jumps to rs1 + simm13, reading rs1 before the write.
- R8: A load (op=3, op3 = 0x00) reads a word at rs1 + simm13 into rd. A store (op=3, op3 = 0x04) writes rd to that address, driving `dmem_we`, `dmem_addr` = address/4 and `dmem_wdata` in the same cycle. Both need bit 13 = 1.
- R9: A store to byte address MEM_BYTES-4 raises `out_valid` in the next cycle, with the stored value on `out_data`.
- R10: These encodings are illegal:
  - any branch condition other than 8, 1 or 9;
  - any op=0 form other than branch or sethi;
  - any op3 outside the set above;
  - sub, subcc, jmpl, load or store with bit 13 = 0.

  An illegal instruction writes nothing. It raises `halted` from the next cycle on, and from then on no state changes until reset.
- R11: Three address faults halt the core exactly as R10 does: a fetch from a PC that is not word-aligned or not below MEM_BYTES, and a load or store whose address has the same defect.
- R12: A call, jmpl or taken branch whose target equals the current PC advances the PC by 4 instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| imem_addr | output | WA | Word index of the instruction being fetched |
| imem_rdata | input | 32 | Instruction word at `imem_addr` |
| dmem_addr | output | WA | Word index of the load or store |
| dmem_rdata | input | 32 | Data word at `dmem_addr` |
| dmem_we | output | 1 | Store strobe, written at the next clock edge |
| dmem_wdata | output | 32 | Store data |
| out_valid | output | 1 | One-cycle strobe after a store to the last word |
| out_data | output | 32 | Value of that store |
| halted | output | 1 | Sticky stop after an illegal instruction or address fault |

## Verification
In jmpl, the link write and the jump target both depend on one register in the same cycle, and the target can also collide with the PC-advance rule. The bench issues a jmpl with rd equal to rs1 and checks that the jump uses the register's old value. It then issues a jmpl to its own address with r0 as the destination, and checks that the PC steps by 4 while the link write is dropped. A reference model restates the instruction semantics and compares every port on every clock. It also compares the last-word output strobe, where two back-to-back stores must produce two consecutive strobes.

// File: rtl/sc_pkg.sv
`timescale 1ns/1ps
package sc_pkg;

  typedef enum logic [3:0] {
    K_CALL, K_BRANCH, K_SETHI, K_ADD, K_SUB, K_SUBCC, K_JMPL, K_LOAD, K_STORE, K_BAD
  } kind_e;

  typedef struct packed {
    kind_e       kind;
    logic [4:0]  rd;
    logic [4:0]  rs1;
    logic [4:0]  src2;     // rs2 for ALU, rd for a store's data
    logic        use_imm;
    logic [3:0]  cond;
    logic [31:0] simm;
    logic [31:0] hi_imm;
    logic [31:0] br_off;
    logic [31:0] call_off;
  } dec_t;

  localparam logic [1:0] OP_CALL  = 2'd1;
  localparam logic [1:0] OP_BRSET = 2'd0;
  localparam logic [1:0] OP_ALU   = 2'd2;
  localparam logic [1:0] OP_MEM   = 2'd3;

  localparam logic [2:0] OP2_BR    = 3'd2;
  localparam logic [2:0] OP2_SETHI = 3'd4;

  localparam logic [5:0] F_ADD   = 6'h00;
  localparam logic [5:0] F_SUB   = 6'h04;
  localparam logic [5:0] F_SUBCC = 6'h14;
  localparam logic [5:0] F_JMPL  = 6'h38;
  localparam logic [5:0] F_LD    = 6'h00;
  localparam logic [5:0] F_ST    = 6'h04;

  localparam logic [3:0] CC_ALWAYS = 4'h8;
  localparam logic [3:0] CC_EQ     = 4'h1;
  localparam logic [3:0] CC_NE     = 4'h9;

  localparam logic [4:0] LINK_REG = 5'd15;

  function automatic logic [31:0] sext13(input logic [12:0] v);
    return {{19{v[12]}}, v};
  endfunction

  function automatic logic [31:0] word_off22(input logic [21:0] d);
    return {{8{d[21]}}, d, 2'b00};
  endfunction

  function automatic logic [31:0] word_off30(input logic [29:0] d);
    return {d, 2'b00};
  endfunction

  function automatic logic cond_known(input logic [3:0] c);
    return (c == CC_ALWAYS) || (c == CC_EQ) || (c == CC_NE);
  endfunction

  function automatic logic cond_met(input logic [3:0] c, input logic z);
    case (c)
      CC_EQ:   return z;
      CC_NE:   return !z;
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic addr_bad(input logic [31:0] a, input logic [31:0] limit);
    return (a[1:0] != 2'b00) || (a >= limit);
  endfunction

endpackage

// File: rtl/sc_decode.sv
`timescale 1ns/1ps
module sc_decode
  import sc_pkg::*;
(
  input  logic [31:0] instr,
  output dec_t        dec
);

  logic [1:0] op;
  logic [2:0] op2;
  logic [5:0] op3;
  logic       imm_sel;

  assign op      = instr[31:30];
  assign op2     = instr[24:22];
  assign op3     = instr[24:19];
  assign imm_sel = instr[13];

  always_comb begin
    dec          = '0;
    dec.kind     = K_BAD;
    dec.rd       = instr[29:25];
    dec.rs1      = instr[18:14];
    dec.src2     = instr[4:0];
    dec.use_imm  = imm_sel;
    dec.cond     = instr[28:25];
    dec.simm     = sext13(instr[12:0]);
    dec.hi_imm   = {instr[21:0], 10'b0};
    dec.br_off   = word_off22(instr[21:0]);
    dec.call_off = word_off30(instr[29:0]);
    case (op)
      OP_CALL: dec.kind = K_CALL;
      OP_BRSET: begin
        if (op2 == OP2_BR && cond_known(instr[28:25])) dec.kind = K_BRANCH;
        else if (op2 == OP2_SETHI)                      dec.kind = K_SETHI;
      end
      OP_ALU: begin
        case (op3)
          F_ADD:   dec.kind = K_ADD;
          F_SUB:   if (imm_sel) dec.kind = K_SUB;
          F_SUBCC: if (imm_sel) dec.kind = K_SUBCC;
          F_JMPL:  if (imm_sel) dec.kind = K_JMPL;
          default: dec.kind = K_BAD;
        endcase
      end
      default: begin
        if (imm_sel && op3 == F_LD) dec.kind = K_LOAD;
        else if (imm_sel && op3 == F_ST) begin
          dec.kind = K_STORE;
          dec.src2 = instr[29:25];
        end
      end
    endcase
  end

endmodule

// File: rtl/sc_regfile.sv
`timescale 1ns/1ps
module sc_regfile #(
  parameter int          W         = 32,
  parameter int          NREG      = 32,
  parameter int          RST_A_IDX = 14,
  parameter logic [31:0] RST_A_VAL = 32'h0,
  parameter int          RST_B_IDX = 8,
  parameter logic [31:0] RST_B_VAL = 32'h0,
  localparam int         IDXW      = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [IDXW-1:0] widx,
  input  logic [W-1:0]    wdata,
  input  logic [IDXW-1:0] ra_idx,
  output logic [W-1:0]    ra_data,
  input  logic [IDXW-1:0] rb_idx,
  output logic [W-1:0]    rb_data
);

  logic [W-1:0] regs [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_ent
    localparam logic [W-1:0] RV = (g == RST_A_IDX) ? W'(RST_A_VAL) :
                                  (g == RST_B_IDX) ? W'(RST_B_VAL) : '0;
    localparam bit WRITABLE = (g != 0);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                      regs[g] <= RV;
      else if (WRITABLE && we && widx == IDXW'(g))     regs[g] <= wdata;
    end
  end

  assign ra_data = regs[ra_idx];
  assign rb_data = regs[rb_idx];

  // R4: the zero register reads zero through either port
  a_r4_zero_read_a: assert property (@(posedge clk) disable iff (!rst_n)
    (ra_idx == '0) |-> (ra_data == '0));
  a_r4_zero_read_b: assert property (@(posedge clk) disable iff (!rst_n)
    (rb_idx == '0) |-> (rb_data == '0));

endmodule

// File: rtl/sc_exec.sv
`timescale 1ns/1ps
module sc_exec
  import sc_pkg::*;
#(
  parameter int unsigned MEM_BYTES = 32'h0002_0000
) (
  input  dec_t        dec,
  input  logic [31:0] pc,
  input  logic [31:0] a,
  input  logic [31:0] b,
  input  logic        z,
  input  logic [31:0] ld_data,
  output logic        wr_en,
  output logic [4:0]  wr_idx,
  output logic [31:0] wr_data,
  output logic [31:0] target,
  output logic        flag_upd,
  output logic        z_new,
  output logic        n_new,
  output logic        st_en,
  output logic [31:0] ea,
  output logic        mem_fault,
  output logic        illegal
);

  localparam logic [31:0] LIMIT = 32'(MEM_BYTES);

  logic [31:0] sum, diff;
  logic        is_mem;

  assign sum  = a + (dec.use_imm ? dec.simm : b);
  assign diff = a - dec.simm;
  assign ea   = a + dec.simm;

  always_comb begin
    wr_en    = 1'b0;
    wr_idx   = dec.rd;
    wr_data  = '0;
    target   = pc;
    flag_upd = 1'b0;
    st_en    = 1'b0;
    is_mem   = 1'b0;
    illegal  = 1'b0;
    case (dec.kind)
      K_CALL: begin
        wr_en   = 1'b1;
        wr_idx  = LINK_REG;
        wr_data = pc;
        target  = pc + dec.call_off;
      end
      K_BRANCH: if (cond_met(dec.cond, z)) target = pc + dec.br_off;
      K_SETHI: begin wr_en = 1'b1; wr_data = dec.hi_imm; end
      K_ADD:   begin wr_en = 1'b1; wr_data = sum; end
      K_SUB:   begin wr_en = 1'b1; wr_data = diff; end
      K_SUBCC: begin wr_en = 1'b1; wr_data = diff; flag_upd = 1'b1; end
      K_JMPL: begin
        wr_en   = 1'b1;
        wr_data = pc;
        target  = ea;
      end
      K_LOAD: begin wr_en = 1'b1; wr_data = ld_data; is_mem = 1'b1; end
      K_STORE: begin st_en = 1'b1; is_mem = 1'b1; end
      default: illegal = 1'b1;
    endcase
  end

  assign z_new     = (diff == '0);
  assign n_new     = diff[31];
  assign mem_fault = is_mem && addr_bad(ea, LIMIT);

endmodule

// File: rtl/scalar_core.sv
`timescale 1ns/1ps
module scalar_core
  import sc_pkg::*;
#(
  parameter int unsigned MEM_BYTES = 32'h0002_0000,
  localparam int         WA        = $clog2(MEM_BYTES / 4)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [WA-1:0] imem_addr,
  input  logic [31:0]   imem_rdata,
  output logic [WA-1:0] dmem_addr,
  input  logic [31:0]   dmem_rdata,
  output logic          dmem_we,
  output logic [31:0]   dmem_wdata,
  output logic          out_valid,
  output logic [31:0]   out_data,
  output logic          halted
);

  localparam logic [31:0] LIMIT     = 32'(MEM_BYTES);
  localparam logic [31:0] LAST_WORD = LIMIT - 32'd4;
  localparam logic [31:0] SP_INIT   = LIMIT - 32'd124;

  logic [31:0] pc_q, next_pc;
  logic        z_q, n_q, halt_q, out_v_q, commit_q;
  logic [31:0] out_d_q;

  dec_t        dec;
  logic [31:0] ra_data, rb_data;
  logic        ex_wr, ex_flag, ex_z, ex_n, ex_st, ex_memf, ex_ill;
  logic [4:0]  ex_widx;
  logic [31:0] ex_wdata, ex_target, ex_ea;

  // named internal events
  logic fetch_fault, fault, commit, last_hit;

  sc_decode u_dec (.instr(imem_rdata), .dec(dec));

  sc_regfile #(
    .W(32), .NREG(32),
    .RST_A_IDX(14), .RST_A_VAL(SP_INIT),
    .RST_B_IDX(8),  .RST_B_VAL(LAST_WORD)
  ) u_rf (
    .clk(clk), .rst_n(rst_n),
    .we(commit && ex_wr), .widx(ex_widx), .wdata(ex_wdata),
    .ra_idx(dec.rs1), .ra_data(ra_data),
    .rb_idx(dec.src2), .rb_data(rb_data)
  );

  sc_exec #(.MEM_BYTES(MEM_BYTES)) u_ex (
    .dec(dec), .pc(pc_q), .a(ra_data), .b(rb_data), .z(z_q), .ld_data(dmem_rdata),
    .wr_en(ex_wr), .wr_idx(ex_widx), .wr_data(ex_wdata), .target(ex_target),
    .flag_upd(ex_flag), .z_new(ex_z), .n_new(ex_n), .st_en(ex_st), .ea(ex_ea),
    .mem_fault(ex_memf), .illegal(ex_ill)
  );

  assign fetch_fault = addr_bad(pc_q, LIMIT);
  assign fault       = fetch_fault || ex_ill || ex_memf;
  assign commit      = !halt_q && !fault;
  assign next_pc     = (ex_target == pc_q) ? pc_q + 32'd4 : ex_target;

  assign imem_addr  = pc_q[WA+1:2];
  assign dmem_addr  = ex_ea[WA+1:2];
  assign dmem_we    = commit && ex_st;
  assign dmem_wdata = rb_data;
  assign last_hit   = dmem_we && (ex_ea == LAST_WORD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q     <= '0;
      z_q      <= 1'b0;
      n_q      <= 1'b0;
      halt_q   <= 1'b0;
      out_v_q  <= 1'b0;
      out_d_q  <= '0;
      commit_q <= 1'b0;
    end else begin
      commit_q <= commit;
      out_v_q  <= last_hit;
      if (last_hit) out_d_q <= rb_data;
      if (!halt_q && fault) halt_q <= 1'b1;
      if (commit) begin
        pc_q <= next_pc;
        if (ex_flag) begin
          z_q <= ex_z;
          n_q <= ex_n;
        end
      end
    end
  end

  assign out_valid = out_v_q;
  assign out_data  = out_d_q;
  assign halted    = halt_q;

  a_r10_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    halt_q |=> halt_q);
  a_r10_quiet_when_halted: assert property (@(posedge clk) disable iff (!rst_n)
    halt_q |-> !dmem_we);
  a_r10_pc_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    halt_q |=> $stable(pc_q));
  a_r11_fault_stops: assert property (@(posedge clk) disable iff (!rst_n)
    (!halt_q && fault) |=> halt_q);
  a_r12_pc_moves: assert property (@(posedge clk) disable iff (!rst_n)
    commit_q |-> (pc_q != $past(pc_q)));
  a_r5_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(commit && ex_flag) |=> ($stable(z_q) && $stable(n_q)));
  a_r9_strobe_after_store: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(dmem_we));

endmodule

// File: tb/scalar_core_tb.sv
`timescale 1ns/1ps
module scalar_core_tb_top;

  localparam int unsigned MEM   = 32'h0002_0000;
  localparam int unsigned WORDS = MEM / 4;
  localparam int          WA    = $clog2(WORDS);

  logic          clk = 1'b0;
  logic          rst_n;
  logic [WA-1:0] imem_addr, dmem_addr;
  logic [31:0]   imem_rdata, dmem_rdata, dmem_wdata, out_data;
  logic          dmem_we, out_valid, halted;

  always #10 clk = ~clk;

  scalar_core #(.MEM_BYTES(MEM)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .imem_addr(imem_addr), .imem_rdata(imem_rdata),
    .dmem_addr(dmem_addr), .dmem_rdata(dmem_rdata),
    .dmem_we(dmem_we), .dmem_wdata(dmem_wdata),
    .out_valid(out_valid), .out_data(out_data), .halted(halted)
  );

  int nchk = 0;
  int nerr = 0;
  bit done = 1'b0;

  logic [31:0] mem [int unsigned];

  function automatic logic [31:0] mem_rd(input int unsigned i);
    if (mem.exists(i)) return mem[i];
    return 32'h0;
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // instruction builders
  function automatic logic [31:0] e3(input int op, input int rd, input int op3,
                                     input int rs1, input int imm);
    return {op[1:0], rd[4:0], op3[5:0], rs1[4:0], 1'b1, imm[12:0]};
  endfunction
  function automatic logic [31:0] e3r(input int op, input int rd, input int op3,
                                      input int rs1, input int rs2);
    return {op[1:0], rd[4:0], op3[5:0], rs1[4:0], 1'b0, 8'h00, rs2[4:0]};
  endfunction
  function automatic logic [31:0] ebr(input int cond, input int disp);
    return {2'b00, 1'b0, cond[3:0], 3'd2, disp[21:0]};
  endfunction
  function automatic logic [31:0] esethi(input int rd, input int imm);
    return {2'b00, rd[4:0], 3'd4, imm[21:0]};
  endfunction
  function automatic logic [31:0] ecall(input int disp);
    return {2'b01, disp[29:0]};
  endfunction

  // reference model state
  int unsigned r [32];
  int unsigned mpc, mod;
  bit          mz, mn, mhalt, mov;
  string       last_tag;
  bit          e_we, e_wr, e_fl, e_bad, e_z, e_n;
  int unsigned e_addr, e_dat, e_idx, e_val, e_tgt;
  string       e_tag;

  task automatic model_reset();
    foreach (r[k]) r[k] = 0;
    r[14] = MEM - 124;
    r[8]  = MEM - 4;
    mpc = 0; mz = 0; mn = 0; mhalt = 0; mov = 0; mod = 0;
    last_tag = "R2";
  endtask

  task automatic model_eval();
    logic [31:0] w;
    int unsigned a, bv, s13, d, ea, rdi, op3;
    e_we = 0; e_wr = 0; e_fl = 0; e_bad = 0; e_tgt = mpc; e_tag = "R2";
    e_addr = 0; e_dat = 0; e_idx = 0; e_val = 0; e_z = 0; e_n = 0;
    if (mhalt) return;
    if ((mpc % 4) != 0 || mpc >= MEM) begin e_bad = 1; e_tag = "R11"; return; end
    w   = mem_rd(mpc / 4);
    rdi = w[29:25];
    op3 = w[24:19];
    a   = r[w[18:14]];
    bv  = r[w[4:0]];
    s13 = w[12] ? 32'(w[12:0]) - 32'h2000 : 32'(w[12:0]);
    case (w[31:30])
      2'd1: begin
        e_wr = 1; e_idx = 15; e_val = mpc; e_tgt = mpc + 32'(w[29:0]) * 4; e_tag = "R7";
      end
      2'd0: begin
        if (w[24:22] == 3'd2) begin
          e_tag = "R6";
          d = w[21] ? 32'(w[21:0]) - 32'h40_0000 : 32'(w[21:0]);
          case (w[28:25])
            4'd8: e_tgt = mpc + d * 4;
            4'd1: if (mz)  e_tgt = mpc + d * 4;
            4'd9: if (!mz) e_tgt = mpc + d * 4;
            default: begin e_bad = 1; e_tag = "R10"; end
          endcase
        end else if (w[24:22] == 3'd4) begin
          e_wr = 1; e_idx = rdi; e_val = 32'(w[21:0]) << 10; e_tag = "R3";
        end else begin e_bad = 1; e_tag = "R10"; end
      end
      2'd2: begin
        e_idx = rdi; e_wr = 1; e_tag = "R3";
        if (op3 == 0) e_val = a + (w[13] ? s13 : bv);
        else if (!w[13]) begin e_bad = 1; e_tag = "R10"; end
        else if (op3 == 4) e_val = a - s13;
        else if (op3 == 'h14) begin
          e_val = a - s13; e_fl = 1; e_z = (e_val == 0); e_n = (e_val >= 32'h8000_0000);
          e_tag = "R5";
        end else if (op3 == 'h38) begin
          e_val = mpc; e_tgt = a + s13; e_tag = "R7";
        end else begin e_bad = 1; e_tag = "R10"; end
      end
      default: begin
        e_tag = "R8";
        ea = a + s13;
        if (!w[13] || (op3 != 0 && op3 != 4)) begin e_bad = 1; e_tag = "R10"; end
        else if ((ea % 4) != 0 || ea >= MEM) begin e_bad = 1; e_tag = "R11"; end
        else if (op3 == 0) begin e_wr = 1; e_idx = rdi; e_val = mem_rd(ea / 4); end
        else begin e_we = 1; e_addr = ea; e_dat = r[rdi]; end
      end
    endcase
    if (e_bad) e_wr = 0;
    if (e_wr && e_idx == 0) e_tag = "R4";
    if ((e_tag == "R6" || e_tag == "R7") && e_tgt == mpc) e_tag = "R12";
  endtask

  task automatic model_commit();
    if (mhalt) begin mov = 0; return; end
    if (e_bad) begin mhalt = 1; mov = 0; last_tag = e_tag; return; end
    if (e_wr && e_idx != 0) r[e_idx] = e_val;
    if (e_fl) begin mz = e_z; mn = e_n; end
    mov = e_we && (e_addr == MEM - 4);
    mod = e_dat;
    mpc = (e_tgt == mpc) ? mpc + 4 : e_tgt;
    last_tag = e_tag;
  endtask

  task automatic cycle_step();
    imem_rdata = mem_rd(32'(imem_addr));
    #1;
    dmem_rdata = mem_rd(32'(dmem_addr));
    #1;
    model_eval();
    chk(32'(imem_addr) == (mpc / 4) % WORDS, last_tag, "fetch address",
        32'(imem_addr), (mpc / 4) % WORDS);
    chk(halted == mhalt, mhalt ? last_tag : "R10", "halted", 32'(halted), 32'(mhalt));
    chk(dmem_we == e_we, e_tag, "store strobe", 32'(dmem_we), 32'(e_we));
    if (e_we) begin
      chk(32'(dmem_addr) == e_addr / 4, "R8", "store address", 32'(dmem_addr), e_addr / 4);
      chk(dmem_wdata == e_dat, "R8", "store data", dmem_wdata, e_dat);
    end
    chk(out_valid == mov, "R9", "output strobe", 32'(out_valid), 32'(mov));
    if (mov) chk(out_data == mod, "R9", "output data", out_data, mod);
    if (dmem_we) mem[32'(dmem_addr)] = dmem_wdata;
    model_commit();
  endtask

  task automatic run(input int cycles);
    @(negedge clk);
    rst_n = 1'b0;
    imem_rdata = '0;
    dmem_rdata = '0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    model_reset();
    // R1: reset state at the ports
    chk(imem_addr == '0, "R1", "reset fetch address", 32'(imem_addr), 32'h0);
    chk(!halted, "R1", "reset halted", 32'(halted), 32'h0);
    chk(!out_valid, "R1", "reset out_valid", 32'(out_valid), 32'h0);
    rst_n = 1'b1;
    for (int c = 0; c < cycles; c++) begin
      cycle_step();
      @(negedge clk);
    end
  endtask

  localparam logic [31:0] BAD = 32'hFFFF_FFFF;

  initial begin
    rst_n = 1'b0;
    imem_rdata = '0;
    dmem_rdata = '0;

    // Program A: main function, R1 values via stores, r0, flags, branches, jmpl hazard
    mem.delete();
    mem[0]  = e3(3, 14, 'h04, 8, 0);    // R1: r14 reset value to last word
    mem[1]  = e3(3, 8, 'h04, 8, 0);     // R9: back-to-back last-word stores
    mem[2]  = esethi(1, 'h12345);
    mem[3]  = e3(2, 2, 0, 1, -1);
    mem[4]  = e3r(2, 3, 0, 1, 2);
    mem[5]  = e3(2, 4, 'h04, 3, 5);
    mem[6]  = e3(2, 0, 0, 1, 1);        // R4: write to r0 dropped
    mem[7]  = e3(2, 5, 0, 0, 7);
    mem[8]  = e3(2, 6, 'h14, 5, 7);     // R5: Z set
    mem[9]  = ebr(1, 2);
    mem[10] = e3(3, 5, 'h04, 0, 'h100);
    mem[11] = ebr(9, 5);
    mem[12] = e3(2, 6, 'h14, 5, 8);     // R5: N set
    mem[13] = ebr(9, 2);
    mem[14] = BAD;
    mem[15] = e3(3, 6, 'h04, 0, 'h100);
    mem[16] = e3(3, 7, 0, 0, 'h100);
    mem[17] = e3(3, 7, 'h04, 8, 0);
    mem[18] = ebr(8, 2);
    mem[19] = BAD;
    mem[20] = ebr(8, 0);                // R12: branch to itself
    mem[21] = ecall(3);                 // R7
    mem[22] = BAD;
    mem[23] = BAD;
    mem[24] = e3(3, 15, 'h04, 0, 'h104);
    mem[25] = e3(2, 9, 0, 0, 112);
    mem[26] = e3(2, 9, 'h38, 9, 0);     // R7: rd equals rs1
    mem[27] = BAD;
    mem[28] = e3(3, 9, 'h04, 8, 0);
    mem[29] = e3(3, 10, 0, 8, 0);
    mem[30] = e3(3, 10, 'h04, 0, 'h108);
    mem[31] = e3(2, 11, 0, 0, 128);
    mem[32] = e3(2, 0, 'h38, 11, 0);    // R12: jmpl to itself, link into r0
    mem[33] = e3(2, 0, 'h14, 5, 7);
    mem[34] = ebr(8, 2);
    mem[35] = BAD;
    mem[36] = e3(2, 12, 0, 12, 1);
    mem[37] = e3(2, 0, 'h14, 12, 3);
    mem[38] = ebr(9, -2);               // R6: backward branch
    mem[39] = e3(3, 12, 'h04, 8, 0);
    mem[40] = e3(3, 4, 'h04, 0, 'h10C);
    mem[41] = e3(3, 3, 'h04, 0, 'h110);
    mem[42] = e3(3, 2, 'h04, 0, 'h114);
    mem[43] = e3(2, 1, 'h3F, 0, 0);     // R10: unknown op3
    run(70);

    // R11: misaligned jump target
    mem.delete();
    mem[0] = e3(2, 1, 0, 0, 2);
    mem[1] = e3(2, 2, 'h38, 1, 0);
    mem[2] = e3(3, 2, 'h04, 0, 'h100);
    run(8);

    // R11: misaligned store
    mem.delete();
    mem[0] = e3(3, 8, 'h04, 0, 2);
    run(5);

    // R11: load beyond memory
    mem.delete();
    mem[0] = e3(3, 1, 0, 8, 4);
    run(5);

    // R11: call to a PC beyond memory
    mem.delete();
    mem[0] = ecall('h8000);
    run(5);

    // R10: unsupported branch condition
    mem.delete();
    mem[0] = ebr(2, 4);
    mem[1] = e3(3, 8, 'h04, 8, 0);
    run(5);

    // R10: sub with register operand
    mem.delete();
    mem[0] = e3r(2, 1, 'h04, 0, 0);
    mem[1] = e3(3, 8, 'h04, 8, 0);
    run(5);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nchk++;
      nerr++;
      $display("FAIL R2 watchdog expired: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

endmodule